// File: doc/BRIEF.md
# Fractional Microsecond Time Base

This block keeps a free-running microsecond count for a chip whose reference oscillator may run at any of several frequencies, including ones that are not whole multiples of 1 MHz. A rational prescaler emits N microsecond ticks for every M oscillator clocks. Software programs both numbers, each stored minus one, in a single 16-bit configuration word. With the right word, 12.8, 16.8, 19.2 and 38.4 MHz oscillators all give an average rate of exactly 1 MHz, and so do the integer cases.

The fraction is kept in a phase accumulator. Every clock adds N, and whenever the sum reaches M a tick is issued and M is taken back off. Ticks are therefore spread as evenly as the ratio allows rather than bunched at the end of each period. Each tick advances the count by one and is also exported as a one-cycle strobe, so other timers can share the same time base. Software reads the count and reads or rewrites the configuration through a small register port. A rewrite is accepted at any time, for example after resume from a low-power state. It restarts the fractional phase and leaves the count alone.

Top module: `usec_prescale_counter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the count reads 0, tick_o is low and the configuration reads back RST_CFG (default 16'h000B).
- R2: A write to offset 0x14 stores wr_data[15:0] as the configuration. Bits [7:0] are the clock count minus one (M-1) and bits [15:8] are the tick count minus one (N-1). A read of 0x14 returns this word in bits [15:0], with bits [31:16] reading zero.
- R3: A read of offset 0x10 returns the count, zero-extended to 32 bits. A read of any other offset returns 0. A write to any offset other than 0x14, 0x10 included, changes neither the count nor the configuration.
- R4: When N <= M, exactly floor(W*N/M) ticks occur in the W clocks that follow a configuration write.
- R5: tick_o is high for exactly one cycle per tick. The count goes up by one in the same cycle that tick_o is high, and it does not change in any other cycle.
- R6: A configuration write leaves the count unchanged, restarts the fractional phase at zero and suppresses the tick in the cycle that follows it.
- R7: When N > M, a tick occurs on every clock.
- R8: The count wraps from 2^CNT_W-1 to 0.
- R9: Ticks are spread evenly. With N=5 and M=64, the spacing between consecutive ticks is always 12 or 13 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data (combinational on addr) |
| tick_o | output | 1 | One-cycle microsecond tick strobe |

## Verification
The hardest situations to reach from the ports are count wrap-around and the exact fractional phase after a reconfiguration. The wrap would need billions of ticks at full width. The bench reaches it with a second instance built with an 8-bit count and a one-to-one ratio, so the count rolls over after 256 clocks. Fractional phase is made deterministic by writing the configuration just before each measurement window, which zeroes the accumulator. The tick total over the window, the count delta and the tick spacing can then be predicted exactly from floor(W*N/M).

// File: rtl/usec_pkg.sv
`timescale 1ns/1ps
package usec_pkg;
  localparam int FIELD_W = 8;
  localparam int CFG_W   = 2 * FIELD_W;
  localparam int ACC_W   = FIELD_W + 2;

  localparam logic [7:0] OFF_COUNT = 8'h10;
  localparam logic [7:0] OFF_CFG   = 8'h14;

  typedef struct packed {
    logic [FIELD_W-1:0] ticks_m1;
    logic [FIELD_W-1:0] clks_m1;
  } usec_cfg_t;

  typedef struct packed {
    logic             fire;
    logic [ACC_W-1:0] nxt;
  } step_t;

  function automatic logic [ACC_W-1:0] cfg_num(usec_cfg_t c);
    return ACC_W'(c.ticks_m1) + ACC_W'(1);
  endfunction

  function automatic logic [ACC_W-1:0] cfg_den(usec_cfg_t c);
    return ACC_W'(c.clks_m1) + ACC_W'(1);
  endfunction

  // one clock of the phase accumulator; at most one tick per clock
  function automatic step_t frac_step(logic [ACC_W-1:0] acc,
                                      logic [ACC_W-1:0] num,
                                      logic [ACC_W-1:0] den);
    step_t r;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] rem;
    sum = acc + num;
    r.fire = 1'b0;
    r.nxt  = sum;
    if (sum >= den) begin
      r.fire = 1'b1;
      rem    = sum - den;
      r.nxt  = (rem >= den) ? '0 : rem;
    end
    return r;
  endfunction
endpackage

// File: rtl/usec_cfg_reg.sv
`timescale 1ns/1ps
module usec_cfg_reg
  import usec_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [CFG_W-1:0] RST_CFG = 16'h000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output usec_cfg_t         cfg_q,
  output logic              cfg_load
);
  assign cfg_load = wr_en && (addr == ADDR_W'(OFF_CFG));

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_q <= usec_cfg_t'(RST_CFG);
    else if (cfg_load) cfg_q <= usec_cfg_t'(wr_data[CFG_W-1:0]);
  end
endmodule

// File: rtl/usec_frac_gen.sv
`timescale 1ns/1ps
module usec_frac_gen
  import usec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  usec_cfg_t        cfg_q,
  input  logic             cfg_load,
  output logic             fire_c,
  output logic [ACC_W-1:0] acc_q,
  output logic             tick_q
);
  step_t st;

  always_comb begin
    st     = frac_step(acc_q, cfg_num(cfg_q), cfg_den(cfg_q));
    fire_c = st.fire && !cfg_load;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_load) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= st.nxt;
      tick_q <= st.fire;
    end
  end
endmodule

// File: rtl/usec_counter.sv
`timescale 1ns/1ps
module usec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count_q <= '0;
    else if (inc) count_q <= count_q + CNT_W'(1);
  end
endmodule

// File: rtl/usec_prescale_counter.sv
`timescale 1ns/1ps
module usec_prescale_counter
  import usec_pkg::*;
#(
  parameter int               ADDR_W  = 8,
  parameter int               CNT_W   = 32,
  parameter logic [CFG_W-1:0] RST_CFG = 16'h000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              tick_o
);
  usec_cfg_t        cfg_q;
  logic             cfg_load;
  logic             fire_c;
  logic [ACC_W-1:0] acc_q;
  logic             tick_q;
  logic [CNT_W-1:0] count_q;

  usec_cfg_reg #(.ADDR_W(ADDR_W), .RST_CFG(RST_CFG)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .cfg_q(cfg_q), .cfg_load(cfg_load)
  );

  usec_frac_gen frac_i (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .cfg_load(cfg_load),
    .fire_c(fire_c), .acc_q(acc_q), .tick_q(tick_q)
  );

  usec_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .inc(fire_c), .count_q(count_q)
  );

  assign tick_o = tick_q;

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(OFF_COUNT))    rd_data = 32'(count_q);
    else if (addr == ADDR_W'(OFF_CFG)) rd_data = 32'(cfg_q);
  end
endmodule

// File: rtl/usec_prescale_counter_chk.sv
`timescale 1ns/1ps
module usec_prescale_counter_chk
  import usec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      wr_data,
  input logic             cfg_load,
  input usec_cfg_t        cfg_q,
  input logic [ACC_W-1:0] acc_q,
  input logic [CNT_W-1:0] count_q,
  input logic             tick_o
);
  // R5
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> count_q == $past(count_q) + CNT_W'(1));

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |-> $stable(count_q));

  // R6
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (!tick_o && acc_q == '0));

  // R2
  cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> cfg_q == $past(wr_data[CFG_W-1:0]));

  // R3
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_q));

  // R4
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < cfg_den(cfg_q));
endmodule

bind usec_prescale_counter usec_prescale_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .cfg_load(cfg_load),
  .cfg_q(cfg_q), .acc_q(acc_q), .count_q(count_q), .tick_o(tick_o)
);

// File: tb/usec_prescale_counter_tb_top.sv
`timescale 1ns/1ps
module usec_prescale_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h10;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick_o;
  logic [31:0] rd_w;
  logic        tick_w;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  usec_prescale_counter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .tick_o(tick_o)
  );

  usec_prescale_counter #(.CNT_W(8), .RST_CFG(16'h0000)) dut_wrap_i (
    .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .addr(8'h10),
    .wr_data(32'h0), .rd_data(rd_w), .tick_o(tick_w)
  );

  // {cfg[15:0], window clocks[15:0], expected ticks[31:0]}
  localparam logic [63:0] VEC [12] = '{
    {16'h000B, 16'd120, 32'd10},
    {16'h043F, 16'd128, 32'd10},
    {16'h0453, 16'd168, 32'd10},
    {16'h045F, 16'd200, 32'd10},
    {16'h04BF, 16'd384, 32'd10},
    {16'h000C, 16'd130, 32'd10},
    {16'h0019, 16'd100, 32'd3},
    {16'h0000, 16'd50,  32'd50},
    {16'h0300, 16'd40,  32'd40},
    {16'h00FF, 16'd600, 32'd2},
    {16'hFFFF, 16'd300, 32'd300},
    {16'h0201, 16'd20,  32'd20}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, c0, c1;
    int ticks, last, gap_bad, seen, found;
    repeat (3) @(negedge clk);
    // R1 during reset
    rd(8'h10, v); check("R1 count in reset", v, 32'h0);
    rd(8'h14, v); check("R1 cfg in reset", v, 32'h0000000B);
    check("R1 tick in reset", 32'(tick_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h10, v); check("R1 count after reset", v, 32'h0);

    // R4 R5 R6 R7 R2: vector walk
    foreach (VEC[i]) begin
      logic [15:0] cfg;
      int win;
      cfg = VEC[i][63:48];
      win = int'(VEC[i][47:32]);
      rd(8'h10, c0);
      wr(8'h14, {16'h0, cfg});
      check("R6 no tick after cfg write", 32'(tick_o), 32'h0);
      rd(8'h10, v); check("R6 count kept on cfg write", v, c0);
      rd(8'h14, v); check("R2 cfg readback", v, {16'h0, cfg});
      ticks = 0;
      for (int k = 0; k < win; k++) begin
        @(negedge clk);
        if (tick_o) ticks++;
      end
      rd(8'h10, c1);
      check("R4/R7 tick total", 32'(ticks), VEC[i][31:0]);
      check("R5 count delta", c1 - c0, VEC[i][31:0]);
    end

    // R2 upper write bits dropped
    wr(8'h14, 32'hABCD_043F);
    rd(8'h14, v); check("R2 upper bits ignored", v, 32'h0000043F);

    // R9 even spacing for 5 ticks per 64 clocks
    last = -1; gap_bad = 0; seen = 0;
    for (int k = 1; k <= 640; k++) begin
      @(negedge clk);
      if (tick_o) begin
        if (last >= 0 && (k - last < 12 || k - last > 13)) gap_bad++;
        last = k; seen++;
      end
    end
    check("R9 tick spacing", 32'(gap_bad), 32'h0);
    check("R9 ticks seen", 32'(seen), 32'd50);

    // R3 writes elsewhere are ignored, reads elsewhere zero
    wr(8'h14, 32'h0000_00FF);
    rd(8'h10, c0);
    wr(8'h10, 32'h1234_5678);
    rd(8'h10, v); check("R3 count write ignored", v, c0);
    wr(8'h18, 32'h0000_0000);
    rd(8'h14, v); check("R3 cfg kept on other write", v, 32'h000000FF);
    rd(8'h20, v); check("R3 unmapped read", v, 32'h0);

    // R8 wrap on the 8-bit instance (one tick per clock)
    found = 0;
    for (int k = 0; k < 400 && found == 0; k++) begin
      @(negedge clk);
      if (rd_w == 32'h000000FF) found = 1;
    end
    check("R8 reached top", 32'(found), 32'h1);
    @(negedge clk);
    check("R8 wrap to zero", rd_w, 32'h0);

    finish_run();
  end
endmodule